// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block keeps a ring of transmit descriptors in its own flop storage and hands them one at a time to a frame consumer. Each descriptor is two 32-bit words. The first is a status word holding the frame length and a set of flags. The second is a buffer pointer. Software reads and writes both words through a small register port, addressed in bytes. Descriptor `i` has its status word at byte `8*i` and its pointer word at byte `8*i + 4`.

The engine side walks the ring in index order. At the current index it checks the ready flag every cycle. When the flag is set, it offers the buffer pointer, length and per-frame options on a valid/ready stream. The consumer accepts by raising `tx_ready` while `tx_valid` is high. That transfer means the frame is done. The engine then clears the ready flag, may raise a one-cycle interrupt, and moves to the next index. It goes back to index 0 after a descriptor that carries the wrap flag.

`tx_valid` depends only on stored state. The consumer may hold `tx_ready` high at any time, or drop it to stall. While `tx_ready` is low, the offer and the index stay where they are.

Status word layout:

| Bits | Meaning |
|------|---------|
| 31:16 | frame length |
| 15 | ready |
| 14 | interrupt request |
| 13 | wrap |
| 12 | pad request |
| 11 | CRC request |

Top module: `txr_ring_mgr`

## Requirements
- R1: After reset, pointer word `i` holds `BUF_BASE + i*0x600` (0x600 = `BUF_SPAN`). Every status word is 0, except the last entry, which holds only the wrap bit (0x0000_2000). The index is 0, and `irq` and `tx_valid` are low.
- R2: `sw_rdata` shows, in the same cycle, the word selected by `sw_addr`. Bit 2 picks the pointer word (1) or the status word (0), the bits above it pick the descriptor, and bits 1:0 are ignored.
- R3: A granted software write (`sw_req`, `sw_we`, `sw_gnt` all high) stores `sw_wdata` into the addressed word at the clock edge.
- R4: `tx_valid` equals bit 15 of the status word at the current index. `tx_ptr` is that descriptor's pointer word, `tx_len` is status bits 31:16, `tx_pad` is bit 12, `tx_crc` is bit 11, and `tx_idx` is the current index.
- R5: A transfer (`tx_valid && tx_ready`) clears bit 15 of the current status word at the edge and leaves its other bits unchanged.
- R6: After a transfer, the index becomes 0 if status bit 13 was set, or if it was the last entry. Otherwise it increments by one.
- R7: `irq` is high for exactly the cycle after a transfer whose status bit 14 was set, and low at all other times.
- R8: With no transfer, the index holds. `tx_ready` raised while `tx_valid` is low has no effect.
- R9: A software write to the status word that a transfer clears in the same cycle is refused (`sw_gnt` low), and the clear takes effect. All other software accesses are granted in the cycle they are requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| sw_req | input | 1 | software access request |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_addr | input | AB (6) | byte address within the ring |
| sw_wdata | input | 32 | write data |
| sw_gnt | output | 1 | access accepted this cycle |
| sw_rdata | output | 32 | addressed word |
| tx_valid | output | 1 | a descriptor is offered |
| tx_ready | input | 1 | consumer accepts / frame done |
| tx_ptr | output | 32 | buffer pointer of the offered descriptor |
| tx_len | output | 16 | frame length |
| tx_pad | output | 1 | pad request flag |
| tx_crc | output | 1 | CRC request flag |
| tx_idx | output | IW (3) | current ring index |
| irq | output | 1 | one-cycle completion interrupt |

## Verification
Two things can happen in the same cycle: the engine clears the ready flag on a completed transfer, and software writes a descriptor word.

The bench provokes this by raising `tx_ready` and a software write in the same cycle. In one case the write targets the status word being cleared. In the other case it targets a different descriptor's pointer. The bench checks the result in two ways: it reads `sw_gnt` in that cycle, and it reads both words back afterwards. The refused write must leave the status word exactly as the clear left it. The unrelated write must land.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int LEN_LSB  = 16;
  localparam int BIT_RDY  = 15;
  localparam int BIT_IRQ  = 14;
  localparam int BIT_WRAP = 13;
  localparam int BIT_PAD  = 12;
  localparam int BIT_CRC  = 11;

  typedef struct packed {
    logic [15:0] len;
    logic        rdy;
    logic        irq;
    logic        wrap;
    logic        pad;
    logic        crc;
  } desc_flags_t;

  function automatic desc_flags_t decode_status(input logic [31:0] w);
    desc_flags_t d;
    d.len  = w[LEN_LSB +: 16];
    d.rdy  = w[BIT_RDY];
    d.irq  = w[BIT_IRQ];
    d.wrap = w[BIT_WRAP];
    d.pad  = w[BIT_PAD];
    d.crc  = w[BIT_CRC];
    return d;
  endfunction
endpackage

// File: rtl/txr_desc_store.sv
module txr_desc_store
  import txr_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int IW        = 3,
  parameter int AB        = 6,
  parameter logic [31:0] BUF_BASE = 32'h0001_0000,
  parameter logic [31:0] BUF_SPAN = 32'h0000_0600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [AB-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic          eng_clr,
  input  logic [IW-1:0] eng_idx,
  output logic [31:0]   eng_status,
  output logic [31:0]   eng_ptr
);
  logic [31:0]   stat_q [DEPTH];
  logic [31:0]   ptr_q  [DEPTH];
  logic [IW-1:0] sw_idx;
  logic          sw_ptr_sel;
  logic          unused_lo;

  assign sw_idx     = sw_addr[AB-1:3];
  assign sw_ptr_sel = sw_addr[2];
  assign unused_lo  = ^sw_addr[1:0];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      localparam logic [31:0] STAT_RST = (gi == DEPTH - 1) ? (32'h1 << BIT_WRAP) : 32'h0;
      localparam logic [31:0] PTR_RST  = BUF_BASE + BUF_SPAN * gi;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stat_q[gi] <= STAT_RST;
          ptr_q[gi]  <= PTR_RST;
        end else begin
          if (eng_clr && eng_idx == IW'(gi))
            stat_q[gi] <= stat_q[gi] & ~(32'h1 << BIT_RDY);
          else if (sw_wr && !sw_ptr_sel && sw_idx == IW'(gi))
            stat_q[gi] <= sw_wdata;
          if (sw_wr && sw_ptr_sel && sw_idx == IW'(gi))
            ptr_q[gi] <= sw_wdata;
        end
      end
    end
  endgenerate

  assign sw_rdata   = sw_ptr_sel ? ptr_q[sw_idx] : stat_q[sw_idx];
  assign eng_status = stat_q[eng_idx];
  assign eng_ptr    = ptr_q[eng_idx];
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cur_status,
  input  logic          tx_ready,
  output logic          fire,
  output logic [IW-1:0] idx,
  output logic          irq
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  desc_flags_t   f;
  logic [IW-1:0] idx_nxt;

  assign f    = decode_status(cur_status);
  assign fire = f.rdy & tx_ready;

  always_comb begin
    idx_nxt = idx;
    if (fire) begin
      if (f.wrap || idx == LAST) idx_nxt = '0;
      else                       idx_nxt = idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      irq <= 1'b0;
    end else begin
      idx <= idx_nxt;
      irq <= fire & f.irq;
    end
  end
endmodule

// File: rtl/txr_ring_mgr.sv
module txr_ring_mgr
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter logic [31:0] BUF_BASE = 32'h0001_0000,
  parameter logic [31:0] BUF_SPAN = 32'h0000_0600,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AB = IW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_req,
  input  logic          sw_we,
  input  logic [AB-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic          sw_gnt,
  output logic [31:0]   sw_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [31:0]   tx_ptr,
  output logic [15:0]   tx_len,
  output logic          tx_pad,
  output logic          tx_crc,
  output logic [IW-1:0] tx_idx,
  output logic          irq
);
  logic [31:0] cur_status;
  logic        fire;
  logic        clash;
  desc_flags_t cur_f;

  // engine wins a same-cycle write to the status word it is clearing
  assign clash  = fire && sw_we && !sw_addr[2] && (sw_addr[AB-1:3] == tx_idx);
  assign sw_gnt = sw_req && !clash;

  txr_desc_store #(
    .DEPTH(DEPTH), .IW(IW), .AB(AB), .BUF_BASE(BUF_BASE), .BUF_SPAN(BUF_SPAN)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr     (sw_gnt && sw_we),
    .sw_addr   (sw_addr),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .eng_clr   (fire),
    .eng_idx   (tx_idx),
    .eng_status(cur_status),
    .eng_ptr   (tx_ptr)
  );

  txr_walker #(.DEPTH(DEPTH), .IW(IW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_status(cur_status),
    .tx_ready  (tx_ready),
    .fire      (fire),
    .idx       (tx_idx),
    .irq       (irq)
  );

  assign cur_f    = decode_status(cur_status);
  assign tx_valid = cur_f.rdy;
  assign tx_len   = cur_f.len;
  assign tx_pad   = cur_f.pad;
  assign tx_crc   = cur_f.crc;
endmodule

// File: rtl/txr_ring_chk.sv
module txr_ring_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_req,
  input logic          sw_gnt,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [IW-1:0] tx_idx,
  input logic          irq,
  input logic [31:0]   cur_status
);
  AST_IRQ_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tx_valid && tx_ready)); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready) |=> $stable(tx_idx)); // R8
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && cur_status[13]) |=> (tx_idx == '0)); // R6
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_valid || tx_idx != $past(tx_idx))); // R5
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gnt |-> sw_req); // R9
endmodule

bind txr_ring_mgr txr_ring_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_gnt(sw_gnt),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx),
  .irq(irq), .cur_status(cur_status)
);

// File: tb/sim_txr_ring_mgr.sv
module sim_txr_ring_mgr;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] SPAN = 32'h0000_0600;
  localparam logic [31:0] RDY  = 32'h0000_8000;
  localparam int NV = 6;
  // {status without ready, pointer}
  localparam logic [63:0] VEC [NV] = '{
    {32'h0364_5800, 32'h0000_1000},
    {32'h0234_0800, 32'h2000_0004},
    {32'h0534_6000, 32'hABCD_0000},
    {32'h0040_1000, 32'h0000_0001},
    {32'hFFFF_5800, 32'hFFFF_FFFC},
    {32'h0001_0000, 32'h1234_5678}
  };

  logic        clk = 0, rst_n = 0;
  logic        sw_req = 0, sw_we = 0, tx_ready = 0;
  logic [5:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic        sw_gnt, tx_valid, tx_pad, tx_crc, irq;
  logic [31:0] sw_rdata, tx_ptr;
  logic [15:0] tx_len;
  logic [2:0]  tx_idx;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  txr_ring_mgr #(.DEPTH(DEPTH), .BUF_BASE(BASE), .BUF_SPAN(SPAN)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sw_write(logic [5:0] a, logic [31:0] d);
    sw_req = 1; sw_we = 1; sw_addr = a; sw_wdata = d;
    step();
    sw_req = 0; sw_we = 0;
  endtask

  task automatic sw_read(logic [5:0] a, output logic [31:0] d);
    sw_addr = a; #1; d = sw_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [2:0]  idx;
    @(negedge clk); @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    chk("R1 idx", 32'(tx_idx), 0);
    chk("R1 valid", 32'(tx_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    for (int i = 0; i < DEPTH; i++) begin
      sw_read(6'(i*8+4), r); chk("R1 ptr", r, BASE + SPAN * i);
      sw_read(6'(i*8), r);   chk("R1 status", r, (i == DEPTH-1) ? 32'h2000 : 32'h0);
    end
    @(negedge clk);
    // R2 low address bits ignored
    sw_read(6'd7, r); chk("R2 low bits", r, BASE);
    // R3 write then read back
    sw_write(6'd12, 32'hCAFE_0010);
    sw_read(6'd12, r); chk("R3 write", r, 32'hCAFE_0010);

    // vector walk
    idx = 0;
    for (int v = 0; v < NV; v++) begin
      logic [31:0] st, pt;
      st = VEC[v][63:32]; pt = VEC[v][31:0];
      sw_write(6'(idx*8+4), pt);
      sw_write(6'(idx*8), st | RDY);
      #1;
      chk("R4 valid", 32'(tx_valid), 1);
      chk("R4 ptr", tx_ptr, pt);
      chk("R4 len", 32'(tx_len), 32'(st[31:16]));
      chk("R4 pad", 32'(tx_pad), 32'(st[12]));
      chk("R4 crc", 32'(tx_crc), 32'(st[11]));
      chk("R4 idx", 32'(tx_idx), 32'(idx));
      @(negedge clk);
      tx_ready = 1;
      step();
      tx_ready = 0; #1;
      chk("R7 irq", 32'(irq), 32'(st[14]));
      sw_read(6'(idx*8), r); chk("R5 cleared", r, st);
      idx = st[13] ? 3'd0 : idx + 3'd1;
      chk("R6 idx", 32'(tx_idx), 32'(idx));
      @(negedge clk); #1;
      chk("R7 pulse end", 32'(irq), 0);
      @(negedge clk);
    end

    // R8 ready while idle has no effect
    tx_ready = 1;
    repeat (3) step();
    tx_ready = 0; #1;
    chk("R8 idle idx", 32'(tx_idx), 32'(idx));
    chk("R8 idle irq", 32'(irq), 0);
    sw_read(6'(idx*8), r); chk("R8 idle status", r, 0);
    @(negedge clk);
    // R8 stall while offered
    sw_write(6'(idx*8), 32'h0005_C000);
    repeat (3) step();
    #1;
    chk("R8 stall valid", 32'(tx_valid), 1);
    chk("R8 stall idx", 32'(tx_idx), 32'(idx));
    @(negedge clk);

    // R9 clash on the status word being cleared
    tx_ready = 1; sw_req = 1; sw_we = 1;
    sw_addr = 6'(idx*8); sw_wdata = 32'h0BAD_8000; #1;
    chk("R9 refused", 32'(sw_gnt), 0);
    @(negedge clk);
    tx_ready = 0; sw_req = 0; sw_we = 0; #1;
    chk("R9 irq", 32'(irq), 1);
    sw_read(6'(idx*8), r); chk("R9 clear wins", r, 32'h0005_4000);
    idx = idx + 3'd1;
    chk("R9 idx", 32'(tx_idx), 32'(idx));
    @(negedge clk);

    // R9 unrelated write during a transfer
    sw_write(6'(idx*8), 32'h0007_8000);
    tx_ready = 1; sw_req = 1; sw_we = 1;
    sw_addr = 6'((idx+3'd1)*8+4); sw_wdata = 32'h5555_0000; #1;
    chk("R9 granted", 32'(sw_gnt), 1);
    @(negedge clk);
    tx_ready = 0; sw_req = 0; sw_we = 0; #1;
    sw_read(6'((idx+3'd1)*8+4), r); chk("R9 other write", r, 32'h5555_0000);
    chk("R7 no irq", 32'(irq), 0);
    chk("R6 step", 32'(tx_idx), 32'(idx + 3'd1));
    finish_run();
  end
endmodule